// File: doc/BRIEF.md
# Maskable Fault Interrupt Status Register

This block gathers eight fault and event indications into a sticky status byte and drives a host interrupt request. The request line is open-drain and active-low; here it is modelled as an output-enable, `irqPullLow`, where 1 means the line is pulled low. A read/write mask byte decides which status bits may pull the line. The mask never stops a bit from being recorded in the status byte.

The host reads the status byte with a one-cycle read strobe. That read returns the current byte and clears it. Any input that rises in the same cycle as the clearing read is kept. After each clearing read, a holdoff window starts and lasts `HOLDOFF_CYCLES` clock cycles. During the window, inputs that are merely still high do not set their bits again. Fresh rising edges do set them. When the window ends, every input that is still high sets its bit again. The request is therefore re-raised after a bounded delay. The holdoff is clamped so that this delay stays within 32 µs at the stated clock frequency.

Status bit order, MSB to LSB:

| Bit | Event |
|-----|-------|
| 7 | LED supply overvoltage |
| 6 | 6 V rail power-good loss |
| 5 | Enable pin low |
| 4 | Mirror-array regulator fault |
| 3 | Undervoltage lockout |
| 2 | Low battery |
| 1 | Thermal shutdown |
| 0 | Thermal warning |

Top module: `fault_irq_unit`

## Requirements
- R1: After reset, the status byte is 0x00, the mask byte is 0xDF (only bit 5 unmasked), and `irqPullLow` is 0.
- R2: An input `evtIn[i]` that is high at a clock edge, outside a holdoff window, sets status bit i at that edge. No status bit becomes set unless its input was high at that edge.
- R3: `irqPullLow` is 1 exactly when (status AND NOT mask) is non-zero. After a mask write that unmasks a pending bit, the request is asserted in the very next cycle.
- R4: A mask bit at 1 stops its status bit from pulling the request. The event still sets the status bit.
- R5: While `statusRd` is high, `statusRdData` shows the status byte. At that clock edge the byte is cleared, except for inputs rising in that same cycle.
- R6: An input held high through a clearing read sets its bit again at the (HOLDOFF_CYCLES+1)-th edge after the read edge, and not before. With the default of 16, that is the 17th edge.
- R7: A rising edge of an input is captured in the read cycle and inside the holdoff window.
- R8: A mask write stores the full byte `maskWrData` at the clock edge. `maskRdData` returns that byte from the next cycle on.
- R9: A set status bit stays set after its input falls, until a clearing read.
- R10: After a clearing read, a bit whose input is low stays clear once the holdoff window ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evtIn | input | 8 | Level event inputs; bit order as in the status byte |
| statusRd | input | 1 | One-cycle strobe: read and clear the status byte |
| statusRdData | output | 8 | Current status byte |
| maskWr | input | 1 | Mask write strobe |
| maskWrData | input | 8 | Mask write data; 1 = masked |
| maskRdData | output | 8 | Current mask byte |
| irqPullLow | output | 1 | Open-drain enable; 1 pulls the request line low |

## Verification
The assertions check on every cycle that:
- a status bit only becomes set when its input was high;
- a set bit drops only at a clearing read;
- a read leaves nothing that was not high at that edge;
- the holdoff counter reloads on every read;
- a mask write lands exactly.

Only the bench scenarios can show the rest: the exact cycle at which a persistent fault re-raises the request, that a masked event still records its bit, that unmasking a pending bit raises the line at once, and that edges are captured during the read cycle and the holdoff window.

// File: rtl/fault_irq_pkg.sv
package fault_irq_pkg;

  // Strobes passed from control to datapath each cycle.
  typedef struct packed {
    logic clearStatus;  // clearing read happens at this edge
    logic levelSetEn;   // still-high inputs may set bits at this edge
    logic maskLoad;     // mask byte loads at this edge
  } irqStrobe_t;

  // Status bit positions (also used for the mask byte).
  localparam int unsigned BIT_THERM_WARN = 0;
  localparam int unsigned BIT_THERM_SHDN = 1;
  localparam int unsigned BIT_BATT_LOW   = 2;
  localparam int unsigned BIT_UNDERVOLT  = 3;
  localparam int unsigned BIT_MIRROR_REG = 4;
  localparam int unsigned BIT_ENABLE_LOW = 5;
  localparam int unsigned BIT_RAIL6_PG   = 6;
  localparam int unsigned BIT_LED_OVP    = 7;

endpackage

// File: rtl/fault_irq_ctrl.sv
module fault_irq_ctrl
  import fault_irq_pkg::*;
#(
  parameter int unsigned HOLDOFF_CYCLES  = 16,
  parameter int unsigned CLK_FREQ_MHZ    = 100,
  parameter int unsigned MAX_REASSERT_NS = 32000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       statusRd,
  input  logic       maskWr,
  output irqStrobe_t stb
);

  // Largest holdoff that still re-raises within the bound: the re-set
  // happens HOLDOFF+1 edges after the read edge.
  localparam int unsigned BOUND_CYC = (CLK_FREQ_MHZ * MAX_REASSERT_NS) / 1000;
  localparam int unsigned MAX_HOLD  = (BOUND_CYC > 1) ? BOUND_CYC - 1 : 0;
  localparam int unsigned EFF_HOLD  = (HOLDOFF_CYCLES > MAX_HOLD) ? MAX_HOLD : HOLDOFF_CYCLES;
  localparam int unsigned CNT_W     = $clog2(EFF_HOLD + 2);
  localparam logic [CNT_W-1:0] HOLD_LOAD = CNT_W'(EFF_HOLD);

  logic [CNT_W-1:0] holdCnt;
  logic             inHoldoff;

  assign inHoldoff = (holdCnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      holdCnt <= '0;
    end else if (statusRd) begin
      holdCnt <= HOLD_LOAD;
    end else if (inHoldoff) begin
      holdCnt <= holdCnt - 1'b1;
    end
  end

  always_comb begin
    stb.clearStatus = statusRd;
    stb.levelSetEn  = !statusRd && !inHoldoff;
    stb.maskLoad    = maskWr;
  end

  // R6
  holdoff_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    statusRd |=> (holdCnt == HOLD_LOAD));

  // R6
  holdoff_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!statusRd && inHoldoff) |=> (holdCnt == $past(holdCnt) - 1'b1));

endmodule

// File: rtl/fault_irq_dpath.sv
module fault_irq_dpath
  import fault_irq_pkg::*;
#(
  parameter int unsigned NUM_EVT = 8,
  parameter logic [NUM_EVT-1:0] MASK_RESET = 8'hDF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evtIn,
  input  irqStrobe_t         stb,
  input  logic [NUM_EVT-1:0] maskWrData,
  output logic [NUM_EVT-1:0] status,
  output logic [NUM_EVT-1:0] mask,
  output logic               irqPullLow
);

  logic [NUM_EVT-1:0] evtPrev;
  logic [NUM_EVT-1:0] evtRise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evtPrev <= '0;
    else        evtPrev <= evtIn;
  end

  assign evtRise = evtIn & ~evtPrev;

  // One sticky flop per event.
  for (genvar i = 0; i < NUM_EVT; i++) begin : g_bit
    logic setNow;
    assign setNow = evtRise[i] || (stb.levelSetEn && evtIn[i]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               status[i] <= 1'b0;
      else if (stb.clearStatus) status[i] <= setNow;
      else if (setNow)          status[i] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            mask <= MASK_RESET;
    else if (stb.maskLoad) mask <= maskWrData;
  end

  always_comb begin
    irqPullLow = |(status & ~mask);
  end

  // R2
  set_needs_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & ~$past(status) & ~$past(evtIn)) == '0));

  // R9
  sticky_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.clearStatus |=> ((status & $past(status)) == $past(status)));

  // R5
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb.clearStatus |=> ((status & ~$past(evtIn)) == '0));

  // R8
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb.maskLoad |=> (mask == $past(maskWrData)));

endmodule

// File: rtl/fault_irq_unit.sv
module fault_irq_unit
  import fault_irq_pkg::*;
#(
  parameter int unsigned NUM_EVT         = 8,
  parameter logic [NUM_EVT-1:0] MASK_RESET = 8'hDF,
  parameter int unsigned HOLDOFF_CYCLES  = 16,
  parameter int unsigned CLK_FREQ_MHZ    = 100,
  parameter int unsigned MAX_REASSERT_NS = 32000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evtIn,
  input  logic               statusRd,
  output logic [NUM_EVT-1:0] statusRdData,
  input  logic               maskWr,
  input  logic [NUM_EVT-1:0] maskWrData,
  output logic [NUM_EVT-1:0] maskRdData,
  output logic               irqPullLow
);

  irqStrobe_t         stb;
  logic [NUM_EVT-1:0] status;
  logic [NUM_EVT-1:0] mask;

  fault_irq_ctrl #(
    .HOLDOFF_CYCLES (HOLDOFF_CYCLES),
    .CLK_FREQ_MHZ   (CLK_FREQ_MHZ),
    .MAX_REASSERT_NS(MAX_REASSERT_NS)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .statusRd(statusRd),
    .maskWr  (maskWr),
    .stb     (stb)
  );

  fault_irq_dpath #(
    .NUM_EVT   (NUM_EVT),
    .MASK_RESET(MASK_RESET)
  ) u_dpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .evtIn     (evtIn),
    .stb       (stb),
    .maskWrData(maskWrData),
    .status    (status),
    .mask      (mask),
    .irqPullLow(irqPullLow)
  );

  assign statusRdData = status;
  assign maskRdData   = mask;

endmodule

// File: tb/tb_fault_irq_unit.sv
module tb_fault_irq_unit;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] evtIn = '0;
  logic       statusRd = 1'b0;
  logic [7:0] statusRdData;
  logic       maskWr = 1'b0;
  logic [7:0] maskWrData = '0;
  logic [7:0] maskRdData;
  logic       irqPullLow;

  int checks = 0;
  int errors = 0;
  localparam int HOLD = 16;

  always #5 clk = ~clk;

  fault_irq_unit dut (
    .clk(clk), .rst_n(rst_n), .evtIn(evtIn), .statusRd(statusRd),
    .statusRdData(statusRdData), .maskWr(maskWr), .maskWrData(maskWrData),
    .maskRdData(maskRdData), .irqPullLow(irqPullLow)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clearRead();
    statusRd = 1'b1;
    step();
    statusRd = 1'b0;
  endtask

  task automatic writeMask(logic [7:0] m);
    maskWr = 1'b1; maskWrData = m;
    step();
    maskWr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 status", statusRdData, 8'h00);
    chk("R1 mask", maskRdData, 8'hDF);
    chk("R1 irq", {7'd0, irqPullLow}, 8'h00);
  endtask

  task automatic t_event_sticky();
    evtIn = 8'h20;
    step();
    evtIn = 8'h00;
    chk("R2 set", statusRdData, 8'h20);
    chk("R3 irq on unmasked", {7'd0, irqPullLow}, 8'h01);
    step(); step();
    chk("R9 sticky", statusRdData, 8'h20);
  endtask

  task automatic t_read_clear();
    statusRd = 1'b1;
    #1;
    chk("R5 read data", statusRdData, 8'h20);
    step();
    statusRd = 1'b0;
    chk("R5 cleared", statusRdData, 8'h00);
    chk("R5 irq released", {7'd0, irqPullLow}, 8'h00);
    for (int k = 0; k < HOLD + 4; k++) step();
    chk("R10 stays clear", statusRdData, 8'h00);
  endtask

  task automatic t_masked();
    evtIn = 8'h01;
    step();
    evtIn = 8'h00;
    chk("R4 masked bit recorded", statusRdData, 8'h01);
    chk("R4 masked no irq", {7'd0, irqPullLow}, 8'h00);
    writeMask(8'h00);
    chk("R3 unmask asserts", {7'd0, irqPullLow}, 8'h01);
    chk("R8 mask readback", maskRdData, 8'h00);
    clearRead();
    writeMask(8'hA5);
    chk("R8 mask full byte", maskRdData, 8'hA5);
    writeMask(8'h00);
  endtask

  task automatic t_persist();
    evtIn = 8'h08;
    step();
    chk("R2 level set", statusRdData, 8'h08);
    clearRead();
    chk("R6 cleared at read", statusRdData, 8'h00);
    for (int k = 1; k < HOLD; k++) step();
    step();
    chk("R6 not before window end", statusRdData, 8'h00);
    chk("R6 irq still released", {7'd0, irqPullLow}, 8'h00);
    step();
    chk("R6 re-set after window", statusRdData, 8'h08);
    chk("R6 irq re-raised", {7'd0, irqPullLow}, 8'h01);
    evtIn = 8'h00;
    clearRead();
    for (int k = 0; k < HOLD + 2; k++) step();
  endtask

  task automatic t_edges();
    evtIn = 8'h40; statusRd = 1'b1;
    step();
    statusRd = 1'b0;
    chk("R7 rise in read cycle kept", statusRdData, 8'h40);
    evtIn = 8'h00;
    step();
    clearRead();
    chk("R5 cleared", statusRdData, 8'h00);
    step(); step();
    evtIn = 8'h02;
    step();
    chk("R7 rise in holdoff", statusRdData, 8'h02);
    evtIn = 8'h00;
    clearRead();
    for (int k = 0; k < HOLD + 2; k++) step();
    chk("R10 clear after window", statusRdData, 8'h00);
  endtask

  initial begin
    #(200000 * 10);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #23;
    t_reset();
    rst_n = 1'b1;
    step();
    t_reset();
    t_event_sticky();
    t_read_clear();
    t_masked();
    t_persist();
    t_edges();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule